// File: doc/BRIEF.md
# Half-Bridge Dead-Time Pair Generator

This block turns a single PWM waveform into two complementary gate-drive signals for the upper and lower switches of a half-bridge. The primary drive follows the PWM high level and the complementary drive follows the PWM low level. Every switch-off reaches its pin at once. Every switch-on is held back by a programmable dead time, so one transistor has fully stopped conducting before its partner starts. The dead time is counted in instruction cycles, which are marked by a one-clock enable pulse that arrives once every four oscillator clocks.

A single state machine owns both outputs. Its states are: `ST_OFF` (both drives off, entered on reset), `ST_PRI_ON` (primary active), `ST_WAIT_CMP` (primary released, complementary pending), `ST_CMP_ON` (complementary active) and `ST_WAIT_PRI` (complementary released, primary pending). Its transitions are:
- **sense-high**: the PWM input is high in `ST_OFF`, `ST_WAIT_CMP` or `ST_CMP_ON`. The machine moves to `ST_WAIT_PRI` and loads the counter, or goes straight to `ST_PRI_ON` when the delay is zero.
- **sense-low**: the mirror image of sense-high, leading to `ST_WAIT_CMP` or `ST_CMP_ON`.
- **expire**: an enable pulse arrives while the count stands at one. This moves `ST_WAIT_PRI` to `ST_PRI_ON`, or `ST_WAIT_CMP` to `ST_CMP_ON`.

A polarity stage after the state machine can invert each pin on its own, so that either drive can be used with active-high or active-low gate drivers.

Top module: `deadtime_pair`

## Requirements
- R1: While the synchronous reset is high, both drives are inactive from the clock edge after reset is first sampled.
- R2: In steady state, a high PWM input makes the primary drive active and the complementary drive inactive. A low PWM input does the opposite.
- R3: When the PWM input changes, the drive that was active goes inactive at the first clock edge that samples the new level, with no added delay.
- R4: With a nonzero delay value N, the newly selected drive becomes active at the edge that samples the N-th enable pulse after the edge that registered the PWM change. An enable pulse on that registering edge is not counted.
- R5: With a delay value of 0, both drives switch on the same edge that registers the PWM change, giving zero dead time.
- R6: The two drives are never active at the same time.
- R7: If the PWM input changes back while a switch-on is pending, the pending drive stays inactive and the count restarts from the full delay value for the other drive.
- R8: The delay value is captured when the count is loaded. A change to it during a count does not alter that count and takes effect at the next PWM change.
- R9: Each polarity input selects its own drive's pin level. A value of 0 means active-high and a value of 1 means active-low, so an inactive drive shows as 1 on the pin.
- R10: The largest delay value, 255, gives exactly 255 enable pulses of dead time.
- R11: The first edge after reset is released treats the current PWM level as a fresh change, and the selected drive turns on after the full delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_en | input | 1 | Instruction-cycle enable, one clock wide, once every four clocks |
| pwm_in | input | 1 | Raw PWM waveform |
| dly | input | DLY_W | Dead time in instruction cycles |
| pol_pri | input | 1 | Primary pin polarity (1 = active-low) |
| pol_cmp | input | 1 | Complementary pin polarity (1 = active-low) |
| drv_pri | output | 1 | Primary gate drive |
| drv_cmp | output | 1 | Complementary gate drive |

## Verification
A state register stuck in a wait state shows up as a drive that never turns on, so the measured pulse count on the next PWM change runs past its expected value. A wrong or skipped counter load moves the turn-on edge by whole instruction cycles, and this is visible within the delay of the affected edge. A wrong transition out of an ON state makes both pins active together, or leaves the old drive asserted, at the first edge after the PWM input changes. Restart and mid-count delay changes are aimed at wrong reload conditions, which surface only when a pending count is disturbed.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_PRI_ON,
        ST_WAIT_CMP,
        ST_CMP_ON,
        ST_WAIT_PRI
    } dt_state_e;

endpackage

// File: rtl/dt_counter.sv
module dt_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic         last
);

    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (tick && (cnt != '0)) begin
            cnt <= cnt - ONE;
        end
    end

    assign last = (cnt == ONE);

endmodule

// File: rtl/dt_fsm.sv
module dt_fsm
    import dtg_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         pwm_in,
    input  logic         cyc_en,
    input  logic [W-1:0] dly,
    input  logic         last,
    output logic         load,
    output logic         counting,
    output logic         pri_act,
    output logic         cmp_act
);

    dt_state_e state_q, state_d;
    logic      no_gap;

    assign no_gap = (dly == '0);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and counter load
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                load = !no_gap;
                if (pwm_in) begin
                    state_d = no_gap ? ST_PRI_ON : ST_WAIT_PRI;
                end else begin
                    state_d = no_gap ? ST_CMP_ON : ST_WAIT_CMP;
                end
            end
            ST_PRI_ON: begin
                if (!pwm_in) begin
                    load    = !no_gap;
                    state_d = no_gap ? ST_CMP_ON : ST_WAIT_CMP;
                end
            end
            ST_WAIT_CMP: begin
                if (pwm_in) begin
                    load    = !no_gap;
                    state_d = no_gap ? ST_PRI_ON : ST_WAIT_PRI;
                end else if (cyc_en && last) begin
                    state_d = ST_CMP_ON;
                end
            end
            ST_CMP_ON: begin
                if (pwm_in) begin
                    load    = !no_gap;
                    state_d = no_gap ? ST_PRI_ON : ST_WAIT_PRI;
                end
            end
            ST_WAIT_PRI: begin
                if (!pwm_in) begin
                    load    = !no_gap;
                    state_d = no_gap ? ST_CMP_ON : ST_WAIT_CMP;
                end else if (cyc_en && last) begin
                    state_d = ST_PRI_ON;
                end
            end
            default: begin
                state_d = ST_OFF;
            end
        endcase
    end

    // outputs decoded from the state register
    always_comb begin
        pri_act  = 1'b0;
        cmp_act  = 1'b0;
        counting = 1'b0;
        unique case (state_q)
            ST_OFF:      ;
            ST_PRI_ON:   pri_act  = 1'b1;
            ST_WAIT_CMP: counting = 1'b1;
            ST_CMP_ON:   cmp_act  = 1'b1;
            ST_WAIT_PRI: counting = 1'b1;
            default:     ;
        endcase
    end

endmodule

// File: rtl/dt_polarity.sv
module dt_polarity #(
    parameter int N = 2
) (
    input  logic [N-1:0] act,
    input  logic [N-1:0] pol,
    output logic [N-1:0] pin
);

    for (genvar i = 0; i < N; i++) begin : g_ch
        assign pin[i] = act[i] ^ pol[i];
    end

endmodule

// File: rtl/deadtime_pair.sv
module deadtime_pair #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cyc_en,
    input  logic             pwm_in,
    input  logic [DLY_W-1:0] dly,
    input  logic             pol_pri,
    input  logic             pol_cmp,
    output logic             drv_pri,
    output logic             drv_cmp
);

    localparam int NCH = 2;

    logic           load;
    logic           counting;
    logic           last;
    logic           tick;
    logic           pri_act;
    logic           cmp_act;
    logic [NCH-1:0] pins;

    assign tick = cyc_en && counting && !load;

    dt_fsm #(.W(DLY_W)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .pwm_in   (pwm_in),
        .cyc_en   (cyc_en),
        .dly      (dly),
        .last     (last),
        .load     (load),
        .counting (counting),
        .pri_act  (pri_act),
        .cmp_act  (cmp_act)
    );

    dt_counter #(.W(DLY_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (dly),
        .tick     (tick),
        .last     (last)
    );

    dt_polarity #(.N(NCH)) u_pol (
        .act ({cmp_act, pri_act}),
        .pol ({pol_cmp, pol_pri}),
        .pin (pins)
    );

    assign drv_pri = pins[0];
    assign drv_cmp = pins[1];

endmodule

// File: rtl/deadtime_pair_chk.sv
module deadtime_pair_chk #(
    parameter int DLY_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             cyc_en,
    input logic             pwm_in,
    input logic [DLY_W-1:0] dly,
    input logic             pol_pri,
    input logic             pol_cmp,
    input logic             drv_pri,
    input logic             drv_cmp
);

    logic pa, ca;
    assign pa = drv_pri ^ pol_pri;
    assign ca = drv_cmp ^ pol_cmp;

    a_r1_reset_off: assert property (@(posedge clk)
        rst |=> (!pa && !ca));

    a_r6_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(pa && ca));

    a_r3_fast_off_pri: assert property (@(posedge clk) disable iff (rst)
        (pa && !pwm_in) |=> !pa);

    a_r3_fast_off_cmp: assert property (@(posedge clk) disable iff (rst)
        (ca && pwm_in) |=> !ca);

    a_r5_zero_gap_cmp: assert property (@(posedge clk) disable iff (rst)
        (pa && !pwm_in && (dly == '0)) |=> ca);

    a_r5_zero_gap_pri: assert property (@(posedge clk) disable iff (rst)
        (ca && pwm_in && (dly == '0)) |=> pa);

    a_r4_on_needs_tick_cmp: assert property (@(posedge clk) disable iff (rst)
        $rose(ca) |-> ($past(cyc_en) || ($past(dly) == '0)));

    a_r4_on_needs_tick_pri: assert property (@(posedge clk) disable iff (rst)
        $rose(pa) |-> ($past(cyc_en) || ($past(dly) == '0)));

    a_r7_pending_cmp_off: assert property (@(posedge clk) disable iff (rst)
        (!ca && pwm_in) |=> !ca);

    a_r7_pending_pri_off: assert property (@(posedge clk) disable iff (rst)
        (!pa && !pwm_in) |=> !pa);

endmodule

bind deadtime_pair deadtime_pair_chk #(.DLY_W(DLY_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cyc_en  (cyc_en),
    .pwm_in  (pwm_in),
    .dly     (dly),
    .pol_pri (pol_pri),
    .pol_cmp (pol_cmp),
    .drv_pri (drv_pri),
    .drv_cmp (drv_cmp)
);

// File: tb/tb_deadtime_pair.sv
module tb_deadtime_pair;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cyc_en = 1'b0;
    logic       pwm = 1'b0;
    logic [7:0] dly = 8'd0;
    logic       pol_pri = 1'b0;
    logic       pol_cmp = 1'b0;
    logic       drv_pri;
    logic       drv_cmp;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    int ph = 0;

    always #5 clk = ~clk;

    deadtime_pair dut (
        .clk     (clk),
        .rst     (rst),
        .cyc_en  (cyc_en),
        .pwm_in  (pwm),
        .dly     (dly),
        .pol_pri (pol_pri),
        .pol_cmp (pol_cmp),
        .drv_pri (drv_pri),
        .drv_cmp (drv_cmp)
    );

    // table: {direction (1 = primary), delay}; expected pulse count = delay
    localparam logic [8:0] VEC [8] = '{
        {1'b1, 8'd0}, {1'b0, 8'd0}, {1'b1, 8'd1}, {1'b0, 8'd2},
        {1'b1, 8'd3}, {1'b0, 8'd7}, {1'b1, 8'd255}, {1'b0, 8'd4}
    };

    function automatic bit pa();
        return drv_pri ^ pol_pri;
    endfunction

    function automatic bit ca();
        return drv_cmp ^ pol_cmp;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // enable pulse generator: one clock high every four
    initial begin
        forever begin
            @(negedge clk);
            ph = (ph + 1) % 4;
            cyc_en = (ph == 0);
        end
    end

    // R6 monitor
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) check(!(pa() && ca()), "R6 overlap", 1, 0);
        end
    end

    // caller has just driven the input at a negedge; next posedge registers it
    task automatic count_on(input bit to_pri, input int exp, input string tag,
                            input bit chg, input logic [7:0] nd);
        int n;
        bit on;
        @(posedge clk);
        @(negedge clk);
        if (to_pri) check(!ca(), "R3 cmp off", int'(ca()), 0);
        else        check(!pa(), "R3 pri off", int'(pa()), 0);
        if (chg) dly = nd;
        n  = 0;
        on = to_pri ? pa() : ca();
        while (!on && n <= 300) begin
            @(posedge clk);
            if (cyc_en) n++;
            @(negedge clk);
            on = to_pri ? pa() : ca();
        end
        check(on && (n == exp), tag, n, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!drv_pri && !drv_cmp, "R1 reset", int'({drv_pri, drv_cmp}), 0);
        rst = 1'b0;
        count_on(1'b0, 0, "R11 first edge", 1'b0, 8'd0);

        for (int i = 0; i < 8; i++) begin
            string tag;
            dly = VEC[i][7:0];
            pwm = VEC[i][8];
            if (VEC[i][7:0] == 8'd0)        tag = "R5 zero gap";
            else if (VEC[i][7:0] == 8'd255) tag = "R10 max delay";
            else                            tag = "R4 delay";
            count_on(VEC[i][8], int'(VEC[i][7:0]), tag, 1'b0, 8'd0);
        end

        // R2 steady levels with PWM low
        repeat (3) @(negedge clk);
        check(ca() && !pa(), "R2 low level", int'({pa(), ca()}), 1);

        // R7 restart while primary pending
        dly = 8'd10;
        pwm = 1'b1;
        @(posedge clk);
        for (int k = 0; k < 3; k++) begin
            @(posedge clk);
            while (!cyc_en) @(posedge clk);
        end
        @(negedge clk);
        check(!pa(), "R7 pending stays off", int'(pa()), 0);
        pwm = 1'b0;
        count_on(1'b0, 10, "R7 restart", 1'b0, 8'd0);

        // R8 mid-count delay change
        dly = 8'd6;
        pwm = 1'b1;
        count_on(1'b1, 6, "R8 old value kept", 1'b1, 8'd20);
        repeat (2) @(negedge clk);
        check(pa() && !ca(), "R2 high level", int'({pa(), ca()}), 2);
        pwm = 1'b0;
        count_on(1'b0, 20, "R8 new value used", 1'b0, 8'd0);

        // R9 polarity
        pol_pri = 1'b1;
        #1;
        check(drv_pri == 1'b1, "R9 pri inactive low-true", int'(drv_pri), 1);
        check(drv_cmp == 1'b1, "R9 cmp active high-true", int'(drv_cmp), 1);
        pol_cmp = 1'b1;
        #1;
        check(drv_cmp == 1'b0, "R9 cmp active low-true", int'(drv_cmp), 0);
        @(negedge clk);
        dly = 8'd2;
        pwm = 1'b1;
        count_on(1'b1, 2, "R9 delay with inversion", 1'b0, 8'd0);
        check(drv_pri == 1'b0 && drv_cmp == 1'b1, "R9 pins",
              int'({drv_pri, drv_cmp}), 1);
        pol_pri = 1'b0;
        pol_cmp = 1'b0;

        // R1 reset mid-run, then R11 restart from reset
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(!drv_pri && !drv_cmp, "R1 reset mid-run", int'({drv_pri, drv_cmp}), 0);
        @(negedge clk);
        dly = 8'd5;
        rst = 1'b0;
        count_on(1'b1, 5, "R11 delayed first edge", 1'b0, 8'd0);

        repeat (4) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule